// File: doc/BRIEF.md
# J-K Two-Input Mealy State Machine

This block is a clocked synchronous state machine with two bits of state, each held in a J-K storage element. It has two data inputs, `in_x` and `in_y`, and one output, `out_z`. Combinational excitation logic drives the J and K pins of each element from the inputs. The output is formed from the present state and the present inputs, so it is a Mealy output: it answers to an input change in the same cycle, before any clock edge.

The lower state bit has a K pin that is tied low. It can therefore be set but never cleared, except by reset. The state is brought out on `state_o` as {upper bit, lower bit}. Reset is asynchronous and active low when asserted. Its release passes through a small synchronizer, so the machine leaves the reset state on a known clock edge.

Top module: `jk_mealy_fsm`

## Requirements
- R1: Each storage element follows next = J·(not Q) + (not K)·Q on the rising clock edge: J,K = 0,0 holds, 0,1 clears, 1,0 sets and 1,1 toggles.
- R2: The upper state bit `state_o[1]` has J = `in_x` and K = `in_x` AND `in_y`. It holds when `in_x`=0, sets when `in_x`=1 and `in_y`=0, and toggles when both inputs are 1.
- R3: The lower state bit `state_o[0]` has J = NOT `in_x` and K = 0. It sets when `in_x`=0 and holds when `in_x`=1, so once it is 1 it stays 1 until reset.
- R4: `out_z` equals (`in_x` AND `state_o[1]`) OR `state_o[0]`. It follows an input change within the same cycle, with no clock edge.
- R5: The state codes on `state_o` are A=00, B=01, C=10 and D=11. From A, any input with `in_x`=0 goes to B and any input with `in_x`=1 goes to C, and `out_z` is 0 for all four inputs.
- R6: From C, inputs (`in_x`,`in_y`) = 00 or 01 give D with `out_z`=0, input 11 gives A with `out_z`=1, and input 10 stays in C with `out_z`=1.
- R7: When `rst_n` goes low, `state_o` becomes 00 at once, without waiting for a clock edge. After `rst_n` returns high, the state stays 00 through the next two rising edges and first follows the inputs on the third.
- R8: For each of the 16 combinations of state and input there is exactly one defined next state and one defined output, with no unknown bits, and they match R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Reset, active low; asserts asynchronously, releases synchronously |
| in_x | input | 1 | First machine input |
| in_y | input | 1 | Second machine input |
| out_z | output | 1 | Mealy output |
| state_o | output | 2 | Present state {upper bit, lower bit} |

## Verification
The bench drives every state through all four input pairs.

- **Full table sweep:** this separates the hold, set and toggle paths of the upper bit, and shows whether `in_y` is wrongly used when `in_x` is 0.
- **Exits from A and C:** these patterns are checked against literal tables, which catches a swapped or inverted excitation term.
- **Sticky lower bit:** a run of mixed inputs from B tests that the lower bit never clears.
- **Reset release:** a release with `in_x`=0 applied shows the exact edge on which the machine first moves, separating a synchronizer that is too short or too long from a correct one.
- **Output timing:** `out_z` is sampled before the clock edge, which tells a true Mealy output apart from a registered one.

// File: rtl/jk_mealy_pkg.sv
package jk_mealy_pkg;
  localparam int STATE_W = 2;
  localparam int HI_BIT  = 1;
  localparam int LO_BIT  = 0;

  typedef enum logic [STATE_W-1:0] {
    ST_A = 2'b00,
    ST_B = 2'b01,
    ST_C = 2'b10,
    ST_D = 2'b11
  } fsm_state_e;
endpackage

// File: rtl/jkm_reset_sync.sv
module jkm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

  // R7: while the pin reset is low the released reset is held low
  a_r7_sync_low: assert property (@(posedge clk) !rst_n |-> !srst_n)
    else $error("a_r7_sync_low");
endmodule

// File: rtl/jkm_jk_bank.sv
module jkm_jk_bank #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] j_i,
  input  logic [WIDTH-1:0] k_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    always_comb begin
      unique case ({j_i[b], k_i[b]})
        2'b00:   q_nxt[b] = q_r[b];
        2'b01:   q_nxt[b] = 1'b0;
        2'b10:   q_nxt[b] = 1'b1;
        default: q_nxt[b] = ~q_r[b];
      endcase
    end

    // R1: the four J-K modes, checked per cell
    a_r1_hold: assert property (@(posedge clk) disable iff (!arst_n)
      (!j_i[b] && !k_i[b]) |=> (q_o[b] == $past(q_o[b])))
      else $error("a_r1_hold");
    a_r1_clear: assert property (@(posedge clk) disable iff (!arst_n)
      (!j_i[b] && k_i[b]) |=> !q_o[b])
      else $error("a_r1_clear");
    a_r1_set: assert property (@(posedge clk) disable iff (!arst_n)
      (j_i[b] && !k_i[b]) |=> q_o[b])
      else $error("a_r1_set");
    a_r1_toggle: assert property (@(posedge clk) disable iff (!arst_n)
      (j_i[b] && k_i[b]) |=> (q_o[b] != $past(q_o[b])))
      else $error("a_r1_toggle");
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_r <= '0;
    else         q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/jkm_excite.sv
module jkm_excite
  import jk_mealy_pkg::*;
(
  input  logic               x_i,
  input  logic               y_i,
  output logic [STATE_W-1:0] j_o,
  output logic [STATE_W-1:0] k_o
);
  always_comb begin
    j_o[HI_BIT] = x_i;
    k_o[HI_BIT] = x_i & y_i;
    j_o[LO_BIT] = ~x_i;
    k_o[LO_BIT] = 1'b0;
  end
endmodule

// File: rtl/jkm_out.sv
module jkm_out
  import jk_mealy_pkg::*;
(
  input  logic               x_i,
  input  logic [STATE_W-1:0] q_i,
  output logic               z_o
);
  always_comb begin
    z_o = (x_i & q_i[HI_BIT]) | q_i[LO_BIT];
  end
endmodule

// File: rtl/jk_mealy_fsm.sv
module jk_mealy_fsm
  import jk_mealy_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_x,
  input  logic               in_y,
  output logic               out_z,
  output logic [STATE_W-1:0] state_o
);
  logic               srst_n;
  logic [STATE_W-1:0] j_w;
  logic [STATE_W-1:0] k_w;
  logic [STATE_W-1:0] q_w;

  jkm_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  jkm_excite u_exc (
    .x_i (in_x),
    .y_i (in_y),
    .j_o (j_w),
    .k_o (k_w)
  );

  jkm_jk_bank #(.WIDTH(STATE_W)) u_bank (
    .clk    (clk),
    .arst_n (srst_n),
    .j_i    (j_w),
    .k_i    (k_w),
    .q_o    (q_w)
  );

  jkm_out u_out (
    .x_i (in_x),
    .q_i (q_w),
    .z_o (out_z)
  );

  assign state_o = q_w;

  // R7: a held reset keeps the machine in A
  a_r7_reset_state: assert property (@(posedge clk) !srst_n |-> (state_o == ST_A))
    else $error("a_r7_reset_state");
  // R3: the lower bit never clears once set
  a_r3_lo_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    state_o[LO_BIT] |=> state_o[LO_BIT])
    else $error("a_r3_lo_sticky");
  // R5: output is low in state A whatever the inputs
  a_r5_a_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o == ST_A) |-> !out_z)
    else $error("a_r5_a_quiet");
  // R6: C with both inputs high returns to A
  a_r6_c_to_a: assert property (@(posedge clk) disable iff (!srst_n)
    ((state_o == ST_C) && in_x && in_y) |=> (state_o == ST_A))
    else $error("a_r6_c_to_a");
  // R2: upper bit holds while in_x is low
  a_r2_hi_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !in_x |=> $stable(state_o[HI_BIT]))
    else $error("a_r2_hi_hold");
endmodule

// File: tb/test_jk_mealy_fsm.sv
`timescale 1ns/1ps
module test_jk_mealy_fsm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_x;
  logic       in_y;
  logic       out_z;
  logic [1:0] state_o;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  jk_mealy_fsm i_jk_mealy_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_x    (in_x),
    .in_y    (in_y),
    .out_z   (out_z),
    .state_o (state_o)
  );

  // Reference from R2/R3 bit rules
  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x, input logic y);
    logic hi, lo;
    if (!x)    hi = s[1];
    else if (!y) hi = 1'b1;
    else       hi = ~s[1];
    lo = x ? s[0] : 1'b1;
    return {hi, lo};
  endfunction

  function automatic logic ref_z(input logic [1:0] s, input logic x);
    return s[0] | (x & s[1]);
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic x, input logic y);
    @(negedge clk);
    in_x = x;
    in_y = y;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    in_x = 1'b0;
    in_y = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic go_to(input logic [1:0] s);
    do_reset();
    case (s)
      2'b01: begin apply(1'b0, 1'b0); tick(); end
      2'b10: begin apply(1'b1, 1'b0); tick(); end
      2'b11: begin apply(1'b1, 1'b0); tick(); apply(1'b0, 1'b0); tick(); end
      default: ;
    endcase
  endtask

  // R7: asynchronous entry and delayed release
  task automatic t_reset;
    go_to(2'b11);
    @(negedge clk);
    rst_n = 1'b0;
    in_x = 1'b0;
    in_y = 1'b0;
    #1 chk("R7 async reset", state_o, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    tick(); chk("R7 hold edge1", state_o, 2'b00);
    tick(); chk("R7 hold edge2", state_o, 2'b00);
    tick(); chk("R7 first move", state_o, 2'b01);
  endtask

  // R5: exits from A
  task automatic t_from_a;
    for (int v = 0; v < 4; v++) begin
      go_to(2'b00);
      apply(v[1], v[0]);
      #1 chk("R5 z in A", {1'b0, out_z}, 2'b00);
      tick(); chk("R5 next from A", state_o, v[1] ? 2'b10 : 2'b01);
    end
  endtask

  // R6: exits from C, literal table
  task automatic t_from_c;
    logic [1:0] nx [4];
    logic       zz [4];
    nx[0] = 2'b11; zz[0] = 1'b0;
    nx[1] = 2'b11; zz[1] = 1'b0;
    nx[2] = 2'b10; zz[2] = 1'b1;
    nx[3] = 2'b00; zz[3] = 1'b1;
    for (int v = 0; v < 4; v++) begin
      go_to(2'b10);
      apply(v[1], v[0]);
      #1 chk("R6 z from C", {1'b0, out_z}, {1'b0, zz[v]});
      tick(); chk("R6 next from C", state_o, nx[v]);
    end
  endtask

  // R3: lower bit stays set under mixed inputs
  task automatic t_sticky;
    go_to(2'b01);
    for (int v = 0; v < 8; v++) begin
      apply(v[0], v[1] ^ v[2]);
      tick(); chk("R3 lower bit sticky", {1'b0, state_o[0]}, 2'b01);
    end
  endtask

  // R4: Mealy output moves with input before the edge
  task automatic t_mealy;
    go_to(2'b10);
    apply(1'b1, 1'b0);
    #1 chk("R4 z with x=1 in C", {1'b0, out_z}, 2'b01);
    in_x = 1'b0;
    #1 chk("R4 z follows x same cycle", {1'b0, out_z}, 2'b00);
    chk("R4 state unchanged pre-edge", state_o, 2'b10);
  endtask

  // R8, R2, R1: full 16-entry sweep
  task automatic t_table;
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 4; v++) begin
        go_to(s[1:0]);
        apply(v[1], v[0]);
        #1 chk("R8 R4 output", {1'b0, out_z}, {1'b0, ref_z(s[1:0], v[1])});
        tick();
        checks++;
        if ($isunknown(state_o)) begin
          failures++;
          $display("FAIL R8 unknown next actual=%b expected=known", state_o);
        end
        chk("R8 R2 R1 next state", state_o, ref_next(s[1:0], v[1], v[0]));
      end
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_x = 1'b0;
    in_y = 1'b0;
    #1 chk("R7 initial reset state", state_o, 2'b00);
    t_reset();
    t_from_a();
    t_from_c();
    t_sticky();
    t_mealy();
    t_table();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule